// File: doc/BRIEF.md
# MDIO Management Interface Controller

This block runs single management transactions toward an Ethernet PHY over the two-wire serial management bus: a clock line (MDC) and a bidirectional data line (MDIO). Software drives it through a small register port. It sets the clock divisor and preamble mode in the control register. For a write it loads the data register. It then writes a command word that names the operation, the PHY address and the register number. The controller shifts the frame out, holds a busy flag while it runs and, for a read, leaves the returned value in the data register.

MDC is derived from the system clock. One MDC period is `field + 1` system clocks, and the control field holds the divisor minus one. A preamble of 32 ones precedes the frame unless preamble suppression is enabled. For a read, the line is released during the turnaround and the data bits. A self-clearing soft reset aborts any transaction in flight.

The sequencer is a single state machine:
- States: `ST_IDLE`, `ST_PREAMBLE`, `ST_HEADER` (start, opcode, PHY address, register number), `ST_TURN`, `ST_DATA` and `ST_SRESET`.
- Transitions: IDLE goes to PREAMBLE on an accepted command, or to HEADER when suppression is on. PREAMBLE goes to HEADER after 32 bits. HEADER goes to TURN after 14 bits. TURN goes to DATA after 2 bits. DATA goes to IDLE after 16 bits.
- A soft-reset write moves any state to SRESET. SRESET returns to IDLE after `RST_CYCLES` clocks.

Register addresses on `reg_addr`: 0 control, 1 command, 2 data, 3 status.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A command write (address 1) made while idle starts a transaction. Bit 15 set selects a read, and it wins if bit 14 is also set. Bit 14 alone selects a write. A command with neither bit set starts nothing.
- R2: After the preamble, the frame sends the following bits MSB first, each bit held for one MDC period and driven with `mdio_oe` high: start `01`, then opcode `10` for a read or `01` for a write, then the PHY address from command bits 9:5, then the register number from command bits 4:0.
- R3: A write sends turnaround `1`,`0` and then the 16-bit data register MSB first, with `mdio_oe` high for every bit.
- R4: A read holds `mdio_oe` low for the two turnaround bits and the 16 data bits. It samples `mdio_i` at each MDC rising edge of the data bits, MSB first. The result is in the data register (address 2, bits 15:0) once busy clears.
- R5: Status bit 0 (address 3) reads 1 for exactly N×D clocks after the command edge and 0 otherwise. N is 64 bits with preamble and 32 without. D is the MDC period.
- R6: D is control bits [9 +: DIVW] plus one, raised to 2 when smaller. In each bit, MDC is low for the first floor(D/2) clocks and high for the rest. MDC and `mdio_oe` are low while idle.
- R7: Control bit 8 set suppresses the preamble. When it is clear, 32 ones with `mdio_oe` high precede the start bits.
- R8: Writing control bit 0 = 1 aborts any transaction and forces MDC and `mdio_oe` low. It clears the data register to 0 and makes control bit 0 read 1 for `RST_CYCLES` clocks, then 0. The divisor and suppression fields take the values written in that same word.
- R9: Command writes and data-register writes made while busy (including during soft reset) are ignored.
- R10: `mdio_o` and `mdio_oe` do not change while MDC stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 data, 3 status |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the register selected by `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
The bench builds the block with `DIVW = 4` and `RST_CYCLES = 3`. The narrow divisor field lets every divisor case finish in a few hundred clocks: the clamp of a zero field to a period of two, an odd period of five with an asymmetric MDC, and an even period of four. The short soft reset makes the abort window and the moment control bit 0 clears easy to hit with a register read. A behavioural model predicts MDC and the busy flag on every clock. A bus-side model captures each bit at the MDC rising edge and returns chosen read data.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_SRESET
    } mdio_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_CMD  = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam int CMD_RD_BIT     = 15;
    localparam int CMD_WR_BIT     = 14;
    localparam int CTRL_SRST_BIT  = 0;
    localparam int CTRL_NOPRE_BIT = 8;
    localparam int CTRL_DIV_LSB   = 9;

    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;
    localparam int DAT_BITS = 16;

endpackage

// File: rtl/mdio_bitclk.sv
module mdio_bitclk #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            kill,
    input  logic [DIVW-1:0] div_m1,
    output logic            mdc,
    output logic            bit_end,
    output logic            rise
);
    localparam int CW = DIVW + 1;

    logic [CW-1:0] period;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        period = {1'b0, div_m1} + CW'(1);
        if (period < CW'(2)) begin
            period = CW'(2);
        end
        half = period >> 1;
    end

    assign bit_end = run && (cnt == period - CW'(1));
    assign rise    = run && (cnt == half - CW'(1));
    assign cnt_nx  = bit_end ? '0 : cnt + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run || kill) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_nx;
            mdc <= (cnt_nx >= half);
        end
    end

endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_pkg::*;
#(
    parameter int DIVW       = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_rd,
    input  logic            go_wr,
    input  logic [4:0]      phy_ad,
    input  logic [4:0]      reg_ad,
    input  logic [15:0]     wr_word,
    input  logic            no_pre,
    input  logic [DIVW-1:0] div_m1,
    input  logic            srst_req,
    input  logic            bit_end,
    input  logic            rise,
    input  logic            mdio_i,
    output mdio_state_e     state_o,
    output logic            run,
    output logic [DIVW-1:0] div_lat,
    output logic            mdio_o,
    output logic            mdio_oe,
    output logic            rd_done,
    output logic [15:0]     rd_word
);
    localparam int RCW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    mdio_state_e state, state_nx;
    logic        is_rd;
    logic [31:0] sh;
    logic [15:0] rx;
    logic [5:0]  bits_left;
    logic [RCW-1:0] srst_cnt;
    logic        last_bit;

    assign last_bit = (bits_left == 6'd1);
    assign state_o  = state;
    assign rd_word  = rx;
    assign rd_done  = (state == ST_DATA) && is_rd && bit_end && last_bit;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (go_rd || go_wr) state_nx = no_pre ? ST_HEADER : ST_PREAMBLE;
            ST_PREAMBLE: if (bit_end && last_bit) state_nx = ST_HEADER;
            ST_HEADER:   if (bit_end && last_bit) state_nx = ST_TURN;
            ST_TURN:     if (bit_end && last_bit) state_nx = ST_DATA;
            ST_DATA:     if (bit_end && last_bit) state_nx = ST_IDLE;
            ST_SRESET:   if (srst_cnt == '0) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
        if (srst_req) begin
            state_nx = ST_SRESET;
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            is_rd     <= 1'b0;
            sh        <= '0;
            rx        <= '0;
            bits_left <= '0;
            srst_cnt  <= '0;
            div_lat   <= '0;
        end else begin
            state <= state_nx;
            if (srst_req) begin
                srst_cnt  <= RCW'(RST_CYCLES - 1);
                rx        <= '0;
                bits_left <= '0;
            end else if (state == ST_SRESET) begin
                if (srst_cnt != '0) srst_cnt <= srst_cnt - RCW'(1);
            end else if (state == ST_IDLE) begin
                if (go_rd || go_wr) begin
                    is_rd     <= go_rd;
                    sh        <= {2'b01, (go_rd ? 2'b10 : 2'b01), phy_ad, reg_ad, 2'b10, wr_word};
                    div_lat   <= div_m1;
                    bits_left <= no_pre ? 6'(HDR_BITS) : 6'(PRE_BITS);
                end
            end else begin
                if (rise && (state == ST_DATA) && is_rd) begin
                    rx <= {rx[14:0], mdio_i};
                end
                if (bit_end) begin
                    if (state != ST_PREAMBLE) begin
                        sh <= {sh[30:0], 1'b0};
                    end
                    if (last_bit) begin
                        unique case (state)
                            ST_PREAMBLE: bits_left <= 6'(HDR_BITS);
                            ST_HEADER:   bits_left <= 6'(TA_BITS);
                            ST_TURN:     bits_left <= 6'(DAT_BITS);
                            default:     bits_left <= '0;
                        endcase
                    end else begin
                        bits_left <= bits_left - 6'd1;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        run     = 1'b0;
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state)
            ST_PREAMBLE: begin
                run     = 1'b1;
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ST_HEADER: begin
                run     = 1'b1;
                mdio_o  = sh[31];
                mdio_oe = 1'b1;
            end
            ST_TURN, ST_DATA: begin
                run     = 1'b1;
                mdio_o  = !is_rd && sh[31];
                mdio_oe = !is_rd;
            end
            default: begin
                run     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DW   = 32,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            busy,
    input  logic            srst_active,
    input  logic            rd_done,
    input  logic [15:0]     rd_word,
    output logic [DW-1:0]   reg_rdata,
    output logic            go_rd,
    output logic            go_wr,
    output logic [4:0]      phy_ad,
    output logic [4:0]      reg_ad,
    output logic [15:0]     wr_word,
    output logic            no_pre,
    output logic [DIVW-1:0] div_m1,
    output logic            srst_req
);
    logic       cmd_sel;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign cmd_sel  = reg_wr && (reg_addr == RA_CMD) && !busy;
    assign go_rd    = cmd_sel && reg_wdata[CMD_RD_BIT];
    assign go_wr    = cmd_sel && !reg_wdata[CMD_RD_BIT] && reg_wdata[CMD_WR_BIT];
    assign phy_ad   = reg_wdata[9:5];
    assign reg_ad   = reg_wdata[4:0];
    assign srst_req = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_SRST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            no_pre  <= 1'b0;
            div_m1  <= '0;
            wr_word <= '0;
        end else begin
            if (reg_wr && (reg_addr == RA_CTRL)) begin
                no_pre <= reg_wdata[CTRL_NOPRE_BIT];
                div_m1 <= reg_wdata[CTRL_DIV_LSB +: DIVW];
            end
            if (srst_req) begin
                wr_word <= '0;
            end else if (rd_done) begin
                wr_word <= rd_word;
            end else if (reg_wr && (reg_addr == RA_DATA) && !busy) begin
                wr_word <= reg_wdata[15:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTRL_DIV_LSB +: DIVW] = div_m1;
                reg_rdata[CTRL_NOPRE_BIT]       = no_pre;
                reg_rdata[CTRL_SRST_BIT]        = srst_active;
            end
            RA_DATA: reg_rdata[15:0] = wr_word;
            RA_STAT: reg_rdata[0]    = busy;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DIVW       = 8,
    parameter int RST_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mdc,
    output logic          mdio_o,
    output logic          mdio_oe,
    input  logic          mdio_i
);
    mdio_state_e     state;
    logic            busy;
    logic            srst_active;
    logic            run;
    logic            bit_end;
    logic            rise;
    logic            go_rd;
    logic            go_wr;
    logic            no_pre;
    logic            srst_req;
    logic            rd_done;
    logic [4:0]      phy_ad;
    logic [4:0]      reg_ad;
    logic [15:0]     wr_word;
    logic [15:0]     rd_word;
    logic [DIVW-1:0] div_m1;
    logic [DIVW-1:0] div_lat;

    assign busy        = (state != ST_IDLE);
    assign srst_active = (state == ST_SRESET);

    mdio_regs #(.DW(DW), .DIVW(DIVW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .srst_active(srst_active),
        .rd_done    (rd_done),
        .rd_word    (rd_word),
        .reg_rdata  (reg_rdata),
        .go_rd      (go_rd),
        .go_wr      (go_wr),
        .phy_ad     (phy_ad),
        .reg_ad     (reg_ad),
        .wr_word    (wr_word),
        .no_pre     (no_pre),
        .div_m1     (div_m1),
        .srst_req   (srst_req)
    );

    mdio_fsm #(.DIVW(DIVW), .RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_rd   (go_rd),
        .go_wr   (go_wr),
        .phy_ad  (phy_ad),
        .reg_ad  (reg_ad),
        .wr_word (wr_word),
        .no_pre  (no_pre),
        .div_m1  (div_m1),
        .srst_req(srst_req),
        .bit_end (bit_end),
        .rise    (rise),
        .mdio_i  (mdio_i),
        .state_o (state),
        .run     (run),
        .div_lat (div_lat),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (rd_done),
        .rd_word (rd_word)
    );

    mdio_bitclk #(.DIVW(DIVW)) u_bitclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .kill   (srst_req),
        .div_m1 (div_lat),
        .mdc    (mdc),
        .bit_end(bit_end),
        .rise   (rise)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          mdc,
    input logic          mdio_o,
    input logic          mdio_oe,
    input logic          busy,
    input logic          srst_active
);
    logic unused_wd;
    assign unused_wd = ^reg_wdata;

    AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && !busy && (reg_wdata[15] || reg_wdata[14])) |=> (busy && !srst_active)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R6

    AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R10

    AST_SRST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> (srst_active && !mdc && !mdio_oe)); // R8

    AST_SRST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_active) |-> !busy); // R8

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    localparam int DW   = 32;
    localparam int DIVW = 4;
    localparam int RSTC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd3;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mdc, mdio_o, mdio_oe;
    logic          mdio_i = 1'b1;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl #(.DW(DW), .DIVW(DIVW), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    int  m_div = 2, m_dlat = 2, m_nopre = 0, m_t = 0, m_tot = 0, m_srst = 0, clk_err = 0;
    bit  m_act = 1'b0;
    // bus-side capture
    logic cap_o [64];
    logic cap_oe[64];
    int   cap_n = 0, data_base = 48;
    logic mdc_prev = 1'b0, o_prev = 1'b0, oe_prev = 1'b0;
    logic [15:0] phy_val = '0;
    // expected frame of the current transaction
    bit e_rd, e_nop;
    logic [4:0] e_pa, e_ra;
    logic [15:0] e_wd;

    function automatic logic bitval(input int j);
        if (j >= data_base && j < data_base + 16) return phy_val[15 - (j - data_base)];
        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_mdc, exp_busy;
            exp_mdc  = m_act && ((m_t % m_dlat) >= (m_dlat / 2));
            exp_busy = m_act || (m_srst > 0);
            if (mdc !== exp_mdc) clk_err++;
            if (reg_addr == 2'd3 && !reg_wr && reg_rdata[0] !== exp_busy) clk_err++;
            if (mdc && mdc_prev && (mdio_o !== o_prev || mdio_oe !== oe_prev)) clk_err++;
            if (mdc && !mdc_prev) begin
                if (cap_n < 64) begin
                    cap_o[cap_n]  = mdio_o;
                    cap_oe[cap_n] = mdio_oe;
                end
                cap_n++;
                mdio_i = bitval(cap_n);
            end
            mdc_prev = mdc; o_prev = mdio_o; oe_prev = mdio_oe;
            if (m_srst > 0) m_srst--;
            if (m_act) begin
                m_t++;
                if (m_t == m_tot) m_act = 1'b0;
            end
            if (reg_wr && reg_addr == 2'd0) begin
                m_div = int'(reg_wdata[9 +: DIVW]) + 1;
                if (m_div < 2) m_div = 2;
                m_nopre = int'(reg_wdata[8]);
                if (reg_wdata[0]) begin
                    m_act = 1'b0;
                    m_srst = RSTC;
                end
            end
            if (reg_wr && reg_addr == 2'd1 && !exp_busy && (reg_wdata[15] || reg_wdata[14])) begin
                m_act = 1'b1; m_t = 0; m_dlat = m_div;
                m_tot = (m_nopre != 0 ? 32 : 64) * m_div;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd3; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_addr = 2'd3;
    endtask

    task automatic xstart(input bit rd_op, input bit both, input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] rv, input int divf, input bit nop);
        logic [DW-1:0] cmd;
        wr(2'd0, (DW'(divf) << 9) | (DW'(nop) << 8));
        if (!rd_op) wr(2'd2, DW'(wd));
        e_rd = rd_op; e_nop = nop; e_pa = pa; e_ra = ra; e_wd = wd;
        phy_val = rv; data_base = (nop ? 0 : 32) + 16;
        cap_n = 0; mdio_i = 1'b1; clk_err = 0;
        cmd = '0;
        cmd[15] = rd_op; cmd[14] = !rd_op || both;
        cmd[9:5] = pa; cmd[4:0] = ra;
        wr(2'd1, cmd);
    endtask

    task automatic xend(output int errs);
        int nb, p, e_pre, e_hdr, e_pay;
        logic [13:0] hdr;
        logic eb;
        e_pre = 0; e_hdr = 0; e_pay = 0;
        while (m_act) @(negedge clk);
        repeat (2) @(negedge clk);
        nb = e_nop ? 32 : 64;
        p  = e_nop ? 0 : 32;
        chk(cap_n == nb, "R7", "MDC rising edge count", cap_n, nb);
        for (int i = 0; i < p; i++)
            if (cap_o[i] !== 1'b1 || cap_oe[i] !== 1'b1) e_pre++;
        chk(e_pre == 0, "R7", "preamble bit errors", e_pre, 0);
        hdr = {2'b01, (e_rd ? 2'b10 : 2'b01), e_pa, e_ra};
        for (int k = 0; k < 14; k++)
            if (cap_o[p + k] !== hdr[13 - k] || cap_oe[p + k] !== 1'b1) e_hdr++;
        chk(e_hdr == 0, "R2", "header bit errors", e_hdr, 0);
        for (int k = 0; k < 18; k++) begin
            if (e_rd) begin
                if (cap_oe[p + 14 + k] !== 1'b0) e_pay++;
            end else begin
                eb = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : e_wd[15 - (k - 2)];
                if (cap_o[p + 14 + k] !== eb || cap_oe[p + 14 + k] !== 1'b1) e_pay++;
            end
        end
        if (e_rd) chk(e_pay == 0, "R4", "released-line errors", e_pay, 0);
        else      chk(e_pay == 0, "R3", "write payload errors", e_pay, 0);
        chk(clk_err == 0, "R5 R6 R10", "per-clock MDC/busy/hold mismatches", clk_err, 0);
        errs = e_pre + e_hdr + e_pay + clk_err;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R5: run did not finish, actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int errs;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd(2'd3, v); chk(v[0] == 1'b0, "R5", "busy after reset", int'(v[0]), 0);
        rd(2'd0, v); chk(v == '0, "R8", "control after reset", int'(v), 0);
        rd(2'd2, v); chk(v == '0, "R4", "data after reset", int'(v), 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R6", "idle lines", int'({mdc, mdio_oe}), 0);

        // write with preamble, period 4
        xstart(1'b0, 1'b0, 5'h11, 5'h0A, 16'hA53C, 16'h0000, 3, 1'b0);
        xend(errs);

        // read without preamble, odd period 5
        xstart(1'b1, 1'b0, 5'h06, 5'h1F, 16'h0000, 16'h9C61, 4, 1'b1);
        xend(errs);
        rd(2'd2, v); chk(v[15:0] == 16'h9C61, "R4", "read result", int'(v[15:0]), 'h9C61);

        // both command bits: read wins, clamped period 2
        xstart(1'b1, 1'b1, 5'h1C, 5'h03, 16'h0000, 16'h3E0F, 0, 1'b0);
        xend(errs);
        chk(errs == 0, "R1", "read selected when both bits set", errs, 0);
        rd(2'd2, v); chk(v[15:0] == 16'h3E0F, "R4", "read result clamp", int'(v[15:0]), 'h3E0F);

        // neither command bit
        cap_n = 0; clk_err = 0;
        wr(2'd1, 32'h0000_0123);
        repeat (20) @(negedge clk);
        rd(2'd3, v); chk(v[0] == 1'b0, "R1", "no start without op bit", int'(v[0]), 0);
        chk(cap_n == 0, "R1", "no MDC edges without op bit", cap_n, 0);

        // writes while busy are ignored
        xstart(1'b0, 1'b0, 5'h03, 5'h07, 16'h1234, 16'h0000, 1, 1'b1);
        repeat (6) @(posedge clk);
        wr(2'd1, 32'h0000_83FF);
        wr(2'd2, 32'h0000_FFFF);
        xend(errs);
        chk(errs == 0, "R9", "frame unchanged by busy writes", errs, 0);
        rd(2'd2, v); chk(v[15:0] == 16'h1234, "R9", "data kept while busy", int'(v[15:0]), 'h1234);

        // soft reset in the middle of a read
        xstart(1'b1, 1'b0, 5'h09, 5'h02, 16'h0000, 16'hBEEF, 3, 1'b0);
        repeat (40) @(posedge clk);
        wr(2'd0, (DW'(3) << 9) | DW'(1));
        rd(2'd0, v); chk(v[0] == 1'b1, "R8", "reset flag during soft reset", int'(v[0]), 1);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8", "lines forced low", int'({mdc, mdio_oe}), 0);
        repeat (6) @(posedge clk);
        rd(2'd0, v); chk(v == (DW'(3) << 9), "R8", "control after soft reset", int'(v), 3 << 9);
        rd(2'd2, v); chk(v == '0, "R8", "data cleared", int'(v), 0);
        rd(2'd3, v); chk(v[0] == 1'b0, "R8", "idle after soft reset", int'(v[0]), 0);
        chk(clk_err == 0, "R5 R6 R8", "per-clock mismatches around abort", clk_err, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule